// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock of an I2C master. Software programs one 16-bit timing register: the upper byte sets the length of the released (high) phase and the lower byte sets the length of the driven-low phase, both in system clock cycles. The block drives the line open-drain style. It either pulls SCL low or lets it go. It never drives it high.

Each phase lasts its programmed count plus one cycles. Before use, each count is raised to its own floor: 2 for the high count and 4 for the low count. Reading the register still returns the value that was written. After it releases the line, the block waits until the synchronized SCL input is seen high before it times the high phase. A slave that holds the line low therefore stretches the clock.

A master-enable input gates the whole block. A run input asks for bit periods back to back. Two one-cycle strobes mark the first cycle of each low phase and each high phase. The surrounding byte engine uses these strobes to change SDA and to sample it.

Top module: `i2c_scl_timer`

## Requirements
- R1: The low count is bits 7:0 of the timing register. Each low phase drives `scl_pull_low` to 1 for exactly (effective low count + 1) consecutive cycles, starting in the cycle in which `low_stb` is 1.
- R2: The high count is bits 15:8 of the timing register. The high phase lasts (effective high count + 1) cycles. These are counted from the cycle in which `high_stb` is 1 up to, but not including, the cycle in which the next `low_stb` is 1 while `run` stays 1.
- R3: A high count of 0 or 1 is used as 2. Any larger value is used unchanged.
- R4: A low count of 0, 1, 2 or 3 is used as 4. Any larger value is used unchanged.
- R5: After reset `cfg_rdata` is 16'h0204. The cycle after a write, `cfg_rdata` holds the 16-bit value written, with no clamping, and bit 7 of each byte is that field's most significant bit.
- R6: While `mst_en` is 0, `scl_pull_low`, `low_stb` and `high_stb` are 0 from the next cycle on. Clearing `mst_en` during a phase ends that phase and returns the block to idle.
- R7: After the low phase, the line stays released and `high_stb` stays 0 for as long as `scl_in` is held low. `high_stb` rises exactly SYNC_STAGES + 1 cycles after the first cycle in which `scl_in` is seen high.
- R8: In idle with `mst_en` at 1, the cycle after `run` is sampled at 1 is the first cycle of a low phase. If `run` is 0 at the end of a high phase, the block goes idle with the line released and starts no further low phase.
- R9: `low_stb` and `high_stb` are each one cycle wide, and the two are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the timing register |
| cfg_wdata | input | 16 | Write data: [15:8] high count, [7:0] low count |
| cfg_rdata | output | 16 | Timing register contents as written |
| mst_en | input | 1 | Master mode enable |
| run | input | 1 | Request for continuous bit periods |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| low_stb | output | 1 | One-cycle mark of the first low-phase cycle |
| high_stb | output | 1 | One-cycle mark of the first high-phase cycle |

## Verification
The bench builds the block with its defaults: 8-bit count fields, floors of 2 and 4, and SYNC_STAGES of 2. With 8-bit fields, every pair of counts from 0 to 11 can be swept, which walks both floors from below and above. A few all-ones and mixed-extreme pairs cover the far end of the counter. The two-stage synchronizer gives a fixed three-cycle delay from line rise to the high strobe. This lets stretching of one to five cycles be inserted on part of the sweep and timed exactly. Separate runs cover the reset value, start latency, a stop at the end of a bit, and an abort by master enable.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // A programmed count below the floor is used as the floor itself.
  function automatic int unsigned raise_to_floor(input int unsigned value,
                                                 input int unsigned floor_v);
    return (value < floor_v) ? floor_v : value;
  endfunction

  // Number of cycles a phase lasts for an effective count.
  function automatic int unsigned phase_cycles(input int unsigned eff_count);
    return eff_count + 1;
  endfunction

endpackage

// File: rtl/i2c_scl_cfg_reg.sv
module i2c_scl_cfg_reg #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned RST_HI  = 2,
  parameter int unsigned RST_LO  = 4,
  localparam int unsigned REG_W  = 2 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [FIELD_W-1:0] hi_raw_o,
  output logic [FIELD_W-1:0] lo_raw_o
);

  logic [FIELD_W-1:0] hi_q;
  logic [FIELD_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= FIELD_W'(RST_HI);
      lo_q <= FIELD_W'(RST_LO);
    end else if (we_i) begin
      hi_q <= wdata_i[REG_W-1:FIELD_W];
      lo_q <= wdata_i[FIELD_W-1:0];
    end
  end

  assign rdata_o  = {hi_q, lo_q};
  assign hi_raw_o = hi_q;
  assign lo_raw_o = lo_q;

endmodule

// File: rtl/i2c_scl_clamp.sv
module i2c_scl_clamp #(
  parameter int unsigned W       = 8,
  parameter int unsigned FLOOR_V = 2
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] eff_o,
  output logic         raised_o
);

  // The arithmetic sits in a package function so that checks can restate it.
  assign eff_o    = W'(i2c_scl_pkg::raise_to_floor(32'(raw_i), FLOOR_V));
  assign raised_o = (32'(raw_i) < FLOOR_V);

endmodule

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  if (STAGES == 0) begin : g_direct
    assign line_o = line_i;
  end else begin : g_chain
    logic [STAGES-1:0] chain_q;

    // An idle bus floats high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
      end else begin
        chain_q <= (chain_q << 1) | STAGES'(line_i);
      end
    end

    assign line_o = chain_q[STAGES-1];
  end

endmodule

// File: rtl/i2c_scl_phase_fsm.sv
module i2c_scl_phase_fsm #(
  parameter int unsigned W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mst_en_i,
  input  logic                    run_i,
  input  logic                    scl_hi_i,
  input  logic [W-1:0]            hi_eff_i,
  input  logic [W-1:0]            lo_eff_i,
  output i2c_scl_pkg::scl_phase_e phase_o,
  output logic                    low_done_o,
  output logic                    high_done_o,
  output logic                    pull_low_o,
  output logic                    low_stb_o,
  output logic                    high_stb_o
);

  import i2c_scl_pkg::*;

  scl_phase_e   phase_q;
  scl_phase_e   phase_d;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         start_req;
  logic         line_seen_high;

  // Greater-or-equal rather than equality: a count lowered by a write in
  // mid-phase still ends the phase instead of running past it.
  assign low_done_o     = (phase_q == PH_LOW)  && (cnt_q >= lo_eff_i);
  assign high_done_o    = (phase_q == PH_HIGH) && (cnt_q >= hi_eff_i);
  assign start_req      = (phase_q == PH_IDLE) && run_i;
  assign line_seen_high = (phase_q == PH_WAIT) && scl_hi_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!mst_en_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_req) begin
            phase_d = PH_LOW;
            cnt_d   = '0;
          end
        end
        PH_LOW: begin
          if (low_done_o) begin
            phase_d = PH_WAIT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + W'(1);
          end
        end
        PH_WAIT: begin
          if (line_seen_high) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
          end
        end
        PH_HIGH: begin
          if (high_done_o) begin
            phase_d = run_i ? PH_LOW : PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + W'(1);
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o    = phase_q;
  assign pull_low_o = (phase_q == PH_LOW);
  assign low_stb_o  = (phase_q == PH_LOW)  && (cnt_q == '0);
  assign high_stb_o = (phase_q == PH_HIGH) && (cnt_q == '0);

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned HI_FLOOR    = 2,
  parameter int unsigned LO_FLOOR    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned REG_W      = 2 * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             mst_en,
  input  logic             run,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             low_stb,
  output logic             high_stb
);

  logic [FIELD_W-1:0]      hi_raw_w;
  logic [FIELD_W-1:0]      lo_raw_w;
  logic [FIELD_W-1:0]      hi_eff_w;
  logic [FIELD_W-1:0]      lo_eff_w;
  logic                    hi_raised_w;
  logic                    lo_raised_w;
  logic                    scl_hi_w;
  logic                    low_done_w;
  logic                    high_done_w;
  i2c_scl_pkg::scl_phase_e phase_w;

  i2c_scl_cfg_reg #(
    .FIELD_W (FIELD_W),
    .RST_HI  (HI_FLOOR),
    .RST_LO  (LO_FLOOR)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we),
    .wdata_i  (cfg_wdata),
    .rdata_o  (cfg_rdata),
    .hi_raw_o (hi_raw_w),
    .lo_raw_o (lo_raw_w)
  );

  i2c_scl_clamp #(.W(FIELD_W), .FLOOR_V(HI_FLOOR)) u_hi_clamp (
    .raw_i    (hi_raw_w),
    .eff_o    (hi_eff_w),
    .raised_o (hi_raised_w)
  );

  i2c_scl_clamp #(.W(FIELD_W), .FLOOR_V(LO_FLOOR)) u_lo_clamp (
    .raw_i    (lo_raw_w),
    .eff_o    (lo_eff_w),
    .raised_o (lo_raised_w)
  );

  i2c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (scl_in),
    .line_o (scl_hi_w)
  );

  i2c_scl_phase_fsm #(.W(FIELD_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mst_en_i    (mst_en),
    .run_i       (run),
    .scl_hi_i    (scl_hi_w),
    .hi_eff_i    (hi_eff_w),
    .lo_eff_i    (lo_eff_w),
    .phase_o     (phase_w),
    .low_done_o  (low_done_w),
    .high_done_o (high_done_w),
    .pull_low_o  (scl_pull_low),
    .low_stb_o   (low_stb),
    .high_stb_o  (high_stb)
  );

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned HI_FLOOR    = 2,
  parameter int unsigned LO_FLOOR    = 4,
  localparam int unsigned REG_W      = 2 * FIELD_W,
  localparam int unsigned RUN_W      = FIELD_W + 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [REG_W-1:0]        cfg_wdata,
  input logic [REG_W-1:0]        cfg_rdata,
  input logic                    mst_en,
  input logic                    run,
  input logic                    scl_pull_low,
  input logic                    low_stb,
  input logic                    high_stb,
  input logic                    scl_hi,
  input logic                    low_done,
  input logic                    high_done,
  input i2c_scl_pkg::scl_phase_e phase
);

  import i2c_scl_pkg::*;

  logic [RUN_W-1:0] lo_run_q;
  logic [RUN_W-1:0] hi_run_q;
  logic             in_high;

  assign in_high = (phase == PH_HIGH);

  // Run-length counters for the driven-low time and the timed-high time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run_q <= '0;
      hi_run_q <= '0;
    end else begin
      lo_run_q <= scl_pull_low ? ((lo_run_q == '1) ? lo_run_q : lo_run_q + RUN_W'(1)) : '0;
      hi_run_q <= in_high      ? ((hi_run_q == '1) ? hi_run_q : hi_run_q + RUN_W'(1)) : '0;
    end
  end

  // R1 / R4: a low phase that ends normally lasts at least the floor + 1.
  p_low_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull_low) && $past(mst_en)) |-> (lo_run_q >= RUN_W'(LO_FLOOR + 1)));

  // R2 / R3: a high phase that ends normally lasts at least the floor + 1.
  p_high_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_high) && $past(mst_en)) |-> (hi_run_q >= RUN_W'(HI_FLOOR + 1)));

  // R1: a finished low phase always hands over to waiting on the line.
  p_low_to_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (low_done && mst_en) |=> (phase == PH_WAIT && !scl_pull_low));

  // R5: the register returns what was written.
  p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

  // R6: master mode off releases the line and silences the strobes.
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_en |=> (!scl_pull_low && !low_stb && !high_stb));

  // R7: a line held low keeps the block waiting.
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !scl_hi && mst_en) |=> (phase == PH_WAIT && !high_stb));

  // R8: a start request in idle opens a low phase on the next cycle.
  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && mst_en && run) |=> low_stb);

  // R8: no run at the end of a high phase means idle.
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (high_done && !run) |=> (phase == PH_IDLE && !scl_pull_low));

  // R9: strobes never overlap and never repeat back to back.
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_stb, high_stb}));

  p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (low_stb || high_stb) |=> !$past(low_stb && low_stb == low_stb) || !low_stb);

endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(
  .FIELD_W  (FIELD_W),
  .HI_FLOOR (HI_FLOOR),
  .LO_FLOOR (LO_FLOOR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .mst_en       (mst_en),
  .run          (run),
  .scl_pull_low (scl_pull_low),
  .low_stb      (low_stb),
  .high_stb     (high_stb),
  .scl_hi       (scl_hi_w),
  .low_done     (low_done_w),
  .high_done    (high_done_w),
  .phase        (phase_w)
);

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;

  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        mst_en = 1'b0;
  logic        run = 1'b0;
  logic        ext_low = 1'b0;
  logic        scl_in;
  logic        scl_pull_low;
  logic        low_stb;
  logic        high_stb;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign scl_in = ~(scl_pull_low | ext_low);

  i2c_scl_timer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .mst_en       (mst_en),
    .run          (run),
    .scl_in       (scl_in),
    .scl_pull_low (scl_pull_low),
    .low_stb      (low_stb),
    .high_stb     (high_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_hi(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int exp_lo(input int v);
    return (v < 4) ? 4 : v;
  endfunction

  task automatic write_cfg(input int hi, input int lo);
    @(negedge clk);
    cfg_wdata = {hi[7:0], lo[7:0]};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == {hi[7:0], lo[7:0]}, "R5 readback", int'(cfg_rdata), (hi << 8) | lo);
  endtask

  // Times one full bit. Ends on the negedge where the next low strobe shows.
  task automatic measure_bit(input int hi, input int lo, input int stretch);
    int n;
    int lo_len;
    int gap;
    int hi_len;
    n = 0;
    while (!low_stb && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(low_stb == 1'b1, "R9 low strobe seen", int'(low_stb), 1);
    ext_low = (stretch > 0);
    lo_len = 0;
    while (scl_pull_low && lo_len < 1000) begin
      lo_len++;
      @(negedge clk);
    end
    chk(lo_len == exp_lo(lo) + 1, "R1 low length (R4 floor)", lo_len, exp_lo(lo) + 1);
    if (stretch > 0) begin
      for (int s = 0; s < stretch; s++) begin
        chk(!high_stb && !scl_pull_low, "R7 held during stretch",
            int'({high_stb, scl_pull_low}), 0);
        @(negedge clk);
      end
      ext_low = 1'b0;
    end
    gap = 0;
    while (!high_stb && gap < 1000) begin
      gap++;
      @(negedge clk);
    end
    chk(gap == SYNC + 1, "R7 line-high to high strobe", gap, SYNC + 1);
    hi_len = 0;
    while (!low_stb && hi_len < 1000) begin
      hi_len++;
      @(negedge clk);
    end
    chk(hi_len == exp_hi(hi) + 1, "R2 high length (R3 floor)", hi_len, exp_hi(hi) + 1);
  endtask

  task automatic abort_run();
    mst_en = 1'b0;
    @(negedge clk);
    chk(!scl_pull_low && !low_stb && !high_stb, "R6 abort releases",
        int'({scl_pull_low, low_stb, high_stb}), 0);
    run = 1'b0;
    @(negedge clk);
    mst_en = 1'b1;
  endtask

  task automatic sweep_one(input int hi, input int lo, input int stretch);
    write_cfg(hi, lo);
    @(negedge clk);
    run = 1'b1;
    measure_bit(hi, lo, stretch);
    abort_run();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int cnt_pull;
    int cnt_lo;
    int cnt_hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk(cfg_rdata == 16'h0204, "R5 reset value", int'(cfg_rdata), 16'h0204);
    chk(!scl_pull_low && !low_stb && !high_stb, "R6 reset outputs idle",
        int'({scl_pull_low, low_stb, high_stb}), 0);

    // Master mode off: run has no effect
    run = 1'b1;
    cnt_pull = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_pull_low || low_stb || high_stb) cnt_pull++;
    end
    chk(cnt_pull == 0, "R6 disabled stays released", cnt_pull, 0);
    run = 1'b0;
    @(negedge clk);

    // Start latency with reset timing
    mst_en = 1'b1;
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    chk(low_stb == 1'b1, "R8 start on next cycle", int'(low_stb), 1);
    measure_bit(2, 4, 0);
    abort_run();

    // Stop at end of bit: hi 3, lo 5
    write_cfg(3, 5);
    @(negedge clk);
    run = 1'b1;
    while (!low_stb) @(negedge clk);
    run = 1'b0;
    cnt_pull = 0;
    cnt_lo = 0;
    cnt_hi = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (scl_pull_low) cnt_pull++;
      if (low_stb) cnt_lo++;
      if (high_stb) cnt_hi++;
    end
    chk(cnt_pull == 5, "R8 stop finishes low phase", cnt_pull, 5);
    chk(cnt_hi == 1, "R8 stop finishes high phase", cnt_hi, 1);
    chk(cnt_lo == 0, "R8 no further bit after stop", cnt_lo, 0);

    // Near-exhaustive sweep across both floors, with stretching on part of it
    for (int h = 0; h < 12; h++) begin
      for (int l = 0; l < 12; l++) begin
        sweep_one(h, l, (((h + l) % 3) == 1) ? ((l % 5) + 1) : 0);
      end
    end
    sweep_one(255, 255, 0);
    sweep_one(255, 0, 2);
    sweep_one(0, 255, 0);
    sweep_one(37, 200, 4);
    sweep_one(128, 129, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule